// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block tells an instruction decoder whether an instruction class that touches privileged state must fault, and with which fault kind. From the current privilege mode, the trap-control bits, the floating-point and vector status fields, the rounding-mode field and three tiers of cache-block enables, it produces one illegal-instruction flag per class and one virtual-instruction flag per class. A separate flag tells the memory side that a cache-block invalidate must be carried out as a flush.

The logic is purely combinational. A parameter chooses whether the flags leave the block directly or through a bank of flops that clears on reset. The decoder sits next to it and uses the flags for whatever instruction class it has decoded.

Top module: `priv_legality_check`

## Requirements
- R1: Privilege is `priv_lvl` (2 bits) plus `virt`. Level 3 is M (virt ignored), level 1 is HS or VS, and level 0 is HU or VU, where virt=1 selects VS/VU. Level 2 matches no mode. In M or level 2, every flag is 0 except ill_o bits 5, 6 and 8.
- R2: Address-translation fence is ill_o[0] = (HS and tvm) or HU, and vrt_o[0] = (VS and vtvm) or VU. Guest-physical fence ill_o[2] uses the same condition as ill_o[0]. Partial fence is ill_o[1] = HU and vrt_o[1] = VU.
- R3: Guest-virtual fence ill_o[3] = HU. Hypervisor load/store ill_o[4] = HU and hu_en=0. Any hypervisor fence vrt_o[2] and hypervisor load/store vrt_o[3] are both set in VS or VU.
- R4: Wait-for-interrupt ill_o[7] = HU, or (any of HS/HU/VS/VU and tw=1). vrt_o[4] = (VU and tw=0) or (VS and tw=0 and vtw=1).
- R5: ill_o[5] = fs_state is 00 (Off). ill_o[6] = vs_state is 00 (Off). ill_o[8] = frm greater than 4. None of these depends on mode.
- R6: Cache-block zero uses enables cbz_en (bit 0 machine, 1 hypervisor, 2 supervisor). ill_o[9] = (non-M mode and machine clear) or (HU and supervisor clear). vrt_o[5] = machine set and ((VS and hypervisor clear) or (VU and hypervisor or supervisor clear)).
- R7: Cache-block clean/flush obeys the R6 rules using cbcf_en, producing ill_o[10] and vrt_o[6].
- R8: Each invalidate setting is 2 bits: 00 Off, 01 Flush, 11 Invalidate, with 10 treated as Off. ill_o[11] = (non-M mode and machine Off) or (HU and supervisor Off). vrt_o[7] = machine not Off and ((VS or VU) and hypervisor Off, or VU and supervisor Off).
- R9: flush_o is set for HS when machine is Flush, for HU when machine or supervisor is Flush, for VS when machine or hypervisor is Flush, and for VU when any of the three is Flush.
- R10: With REG_OUT=0, the flags follow the inputs in the same cycle. With REG_OUT=1, they show the inputs sampled at the previous rising clock edge, and they are all 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Privilege level |
| virt | input | 1 | Virtualization mode |
| tvm | input | 1 | Trap translation management at supervisor |
| tw | input | 1 | Trap wait-for-interrupt outside M |
| vtvm | input | 1 | Trap translation management for guests |
| vtw | input | 1 | Trap wait-for-interrupt for guests |
| hu_en | input | 1 | Allows hypervisor load/store from HU |
| fs_state | input | 2 | Floating-point status field |
| vs_state | input | 2 | Vector status field |
| frm | input | 3 | Rounding-mode field |
| cbz_en | input | 3 | Cache-block zero enables (machine, hypervisor, supervisor) |
| cbcf_en | input | 3 | Cache-block clean/flush enables (same order) |
| cbi_m | input | 2 | Machine-tier invalidate setting |
| cbi_h | input | 2 | Hypervisor-tier invalidate setting |
| cbi_s | input | 2 | Supervisor-tier invalidate setting |
| ill_o | output | 12 | Illegal-instruction flags per class |
| vrt_o | output | 8 | Virtual-instruction flags per class |
| flush_o | output | 1 | Invalidate to be performed as flush |

## Verification
The bench sweeps every privilege encoding, including the unused level 2 and level 3 with virt set, under random trap bits and random enable tiers. This shows whether each fault lands on the right mode and on the right kind. Directed patterns set a single tier to a single value, including the reserved invalidate code 10. These separate the machine, hypervisor and supervisor tiers and the Off, Flush and Invalidate outcomes. One instance of each output variant is compared against the same model: the combinational one within the cycle, and the registered one after the next edge and during reset.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int LVL_W  = 2;
  localparam int STAT_W = 2;
  localparam int FRM_W  = 3;
  localparam int TIER_N = 3;
  localparam int CBI_W  = 2;
  localparam int FRM_MAX = 4;

  localparam int ILL_N = 12;
  localparam int VRT_N = 8;

  // illegal flag positions
  localparam int IL_ATFENCE = 0;
  localparam int IL_PFENCE  = 1;
  localparam int IL_GFENCE  = 2;
  localparam int IL_VFENCE  = 3;
  localparam int IL_HLDST   = 4;
  localparam int IL_FPOFF   = 5;
  localparam int IL_VECOFF  = 6;
  localparam int IL_WFI     = 7;
  localparam int IL_FRMRSV  = 8;
  localparam int IL_CBZ     = 9;   // clean/flush follows at +1
  localparam int IL_CBI     = 11;

  // virtual flag positions
  localparam int VF_ATFENCE = 0;
  localparam int VF_PFENCE  = 1;
  localparam int VF_HFENCE  = 2;
  localparam int VF_HLDST   = 3;
  localparam int VF_WFI     = 4;
  localparam int VF_CBZ     = 5;   // clean/flush follows at +1
  localparam int VF_CBI     = 7;

  // tier indices inside an enable vector
  localparam int T_MACH = 0;
  localparam int T_HYP  = 1;
  localparam int T_SUP  = 2;

  localparam logic [LVL_W-1:0] LVL_M = 2'd3;
  localparam logic [LVL_W-1:0] LVL_S = 2'd1;
  localparam logic [LVL_W-1:0] LVL_U = 2'd0;

  typedef enum logic [CBI_W-1:0] {
    CBI_OFF   = 2'b00,
    CBI_FLUSH = 2'b01,
    CBI_RSVD  = 2'b10,
    CBI_INV   = 2'b11
  } cbi_e;

  typedef struct packed {
    logic m;
    logic hs;
    logic hu;
    logic vs;
    logic vu;
  } mode_t;
endpackage

// File: rtl/plc_mode_dec.sv
module plc_mode_dec
  import plc_pkg::*;
(
  input  logic [LVL_W-1:0] priv_lvl,
  input  logic             virt,
  output mode_t            mode
);
  always_comb begin
    mode    = '0;
    mode.m  = (priv_lvl == LVL_M);
    mode.hs = (priv_lvl == LVL_S) && !virt;
    mode.hu = (priv_lvl == LVL_U) && !virt;
    mode.vs = (priv_lvl == LVL_S) &&  virt;
    mode.vu = (priv_lvl == LVL_U) &&  virt;
  end
endmodule

// File: rtl/plc_trap_rules.sv
module plc_trap_rules
  import plc_pkg::*;
(
  input  mode_t              mode,
  input  logic               tvm,
  input  logic               tw,
  input  logic               vtvm,
  input  logic               vtw,
  input  logic               hu_en,
  input  logic [STAT_W-1:0]  fs_state,
  input  logic [STAT_W-1:0]  vs_state,
  input  logic [FRM_W-1:0]   frm,
  output logic [ILL_N-1:0]   ill_part,
  output logic [VRT_N-1:0]   vrt_part
);
  logic below_m;
  logic guest;

  always_comb begin
    below_m = mode.hs | mode.hu | mode.vs | mode.vu;
    guest   = mode.vs | mode.vu;

    ill_part = '0;
    ill_part[IL_ATFENCE] = (mode.hs & tvm) | mode.hu;
    ill_part[IL_GFENCE]  = (mode.hs & tvm) | mode.hu;
    ill_part[IL_PFENCE]  = mode.hu;
    ill_part[IL_VFENCE]  = mode.hu;
    ill_part[IL_HLDST]   = mode.hu & ~hu_en;
    ill_part[IL_WFI]     = mode.hu | (below_m & tw);
    ill_part[IL_FPOFF]   = (fs_state == '0);
    ill_part[IL_VECOFF]  = (vs_state == '0);
    ill_part[IL_FRMRSV]  = (frm > FRM_W'(FRM_MAX));

    vrt_part = '0;
    vrt_part[VF_ATFENCE] = (mode.vs & vtvm) | mode.vu;
    vrt_part[VF_PFENCE]  = mode.vu;
    vrt_part[VF_HFENCE]  = guest;
    vrt_part[VF_HLDST]   = guest;
    vrt_part[VF_WFI]     = ~tw & (mode.vu | (mode.vs & vtw));
  end
endmodule

// File: rtl/plc_cbo_rules.sv
module plc_cbo_rules
  import plc_pkg::*;
(
  input  mode_t              mode,
  input  logic [TIER_N-1:0]  cbz_en,
  input  logic [TIER_N-1:0]  cbcf_en,
  input  logic [CBI_W-1:0]   cbi_m,
  input  logic [CBI_W-1:0]   cbi_h,
  input  logic [CBI_W-1:0]   cbi_s,
  output logic [ILL_N-1:0]   ill_part,
  output logic [VRT_N-1:0]   vrt_part,
  output logic               flush
);
  localparam int KINDS = 2;

  logic below_m;
  logic [TIER_N-1:0] en_tab [KINDS];
  logic [KINDS-1:0]  k_ill;
  logic [KINDS-1:0]  k_vrt;
  logic m_off, h_off, s_off, m_fl, h_fl, s_fl;

  assign below_m   = mode.hs | mode.hu | mode.vs | mode.vu;
  assign en_tab[0] = cbz_en;
  assign en_tab[1] = cbcf_en;

  // zero and clean/flush share one rule shape
  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    assign k_ill[k] = (below_m & ~en_tab[k][T_MACH]) |
                      (mode.hu & ~en_tab[k][T_SUP]);
    assign k_vrt[k] = en_tab[k][T_MACH] &
                      ((mode.vs & ~en_tab[k][T_HYP]) |
                       (mode.vu & (~en_tab[k][T_HYP] | ~en_tab[k][T_SUP])));
  end

  // reserved code 10 behaves as Off: only bit 0 separates Off from the rest
  assign m_off = ~cbi_m[0];
  assign h_off = ~cbi_h[0];
  assign s_off = ~cbi_s[0];
  assign m_fl  = (cbi_m == CBI_FLUSH);
  assign h_fl  = (cbi_h == CBI_FLUSH);
  assign s_fl  = (cbi_s == CBI_FLUSH);

  always_comb begin
    ill_part = '0;
    vrt_part = '0;
    for (int k = 0; k < KINDS; k++) begin
      ill_part[IL_CBZ + k] = k_ill[k];
      vrt_part[VF_CBZ + k] = k_vrt[k];
    end
    ill_part[IL_CBI] = (below_m & m_off) | (mode.hu & s_off);
    vrt_part[VF_CBI] = ~m_off & (((mode.vs | mode.vu) & h_off) | (mode.vu & s_off));
    flush = (mode.hs & m_fl) |
            (mode.hu & (m_fl | s_fl)) |
            (mode.vs & (m_fl | h_fl)) |
            (mode.vu & (m_fl | h_fl | s_fl));
  end
endmodule

// File: rtl/plc_out_stage.sv
module plc_out_stage #(
  parameter bit REG_OUT = 1'b1,
  parameter int W       = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG_OUT) begin : g_reg
    logic [W-1:0] q_nxt;
    logic [W-1:0] q_r;
    always_comb q_nxt = d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_nxt;
    end
    assign q = q_r;
  end else begin : g_comb
    assign q = d;
  end
endmodule

// File: rtl/priv_legality_check.sv
module priv_legality_check
  import plc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LVL_W-1:0]    priv_lvl,
  input  logic                virt,
  input  logic                tvm,
  input  logic                tw,
  input  logic                vtvm,
  input  logic                vtw,
  input  logic                hu_en,
  input  logic [STAT_W-1:0]   fs_state,
  input  logic [STAT_W-1:0]   vs_state,
  input  logic [FRM_W-1:0]    frm,
  input  logic [TIER_N-1:0]   cbz_en,
  input  logic [TIER_N-1:0]   cbcf_en,
  input  logic [CBI_W-1:0]    cbi_m,
  input  logic [CBI_W-1:0]    cbi_h,
  input  logic [CBI_W-1:0]    cbi_s,
  output logic [ILL_N-1:0]    ill_o,
  output logic [VRT_N-1:0]    vrt_o,
  output logic                flush_o
);
  localparam int OUT_W = ILL_N + VRT_N + 1;

  mode_t            mode;
  logic [ILL_N-1:0] ill_trap, ill_cbo;
  logic [VRT_N-1:0] vrt_trap, vrt_cbo;
  logic             flush_c;
  logic [OUT_W-1:0] flags_c, flags_q;

  plc_mode_dec u_mode (
    .priv_lvl (priv_lvl),
    .virt     (virt),
    .mode     (mode)
  );

  plc_trap_rules u_trap (
    .mode     (mode),
    .tvm      (tvm),
    .tw       (tw),
    .vtvm     (vtvm),
    .vtw      (vtw),
    .hu_en    (hu_en),
    .fs_state (fs_state),
    .vs_state (vs_state),
    .frm      (frm),
    .ill_part (ill_trap),
    .vrt_part (vrt_trap)
  );

  plc_cbo_rules u_cbo (
    .mode     (mode),
    .cbz_en   (cbz_en),
    .cbcf_en  (cbcf_en),
    .cbi_m    (cbi_m),
    .cbi_h    (cbi_h),
    .cbi_s    (cbi_s),
    .ill_part (ill_cbo),
    .vrt_part (vrt_cbo),
    .flush    (flush_c)
  );

  assign flags_c = {flush_c, vrt_trap | vrt_cbo, ill_trap | ill_cbo};

  plc_out_stage #(.REG_OUT(REG_OUT), .W(OUT_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (flags_c),
    .q     (flags_q)
  );

  assign ill_o   = flags_q[ILL_N-1:0];
  assign vrt_o   = flags_q[ILL_N +: VRT_N];
  assign flush_o = flags_q[OUT_W-1];
endmodule

module plc_checker
  import plc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] priv_lvl,
  input logic             virt,
  input logic [FRM_W-1:0] frm,
  input logic [ILL_N-1:0] ill_o,
  input logic [VRT_N-1:0] vrt_o,
  input logic             flush_o
);
  localparam logic [ILL_N-1:0] MODE_FREE =
    (ILL_N'(1) << IL_FPOFF) | (ILL_N'(1) << IL_VECOFF) | (ILL_N'(1) << IL_FRMRSV);

  logic [LVL_W-1:0] lvl_d;
  logic             virt_d;
  logic [FRM_W-1:0] frm_d;
  logic             armed;

  if (REG_OUT) begin : g_lag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_d  <= '0;
        virt_d <= 1'b0;
        frm_d  <= '0;
        armed  <= 1'b0;
      end else begin
        lvl_d  <= priv_lvl;
        virt_d <= virt;
        frm_d  <= frm;
        armed  <= 1'b1;
      end
    end
  end else begin : g_now
    assign lvl_d  = priv_lvl;
    assign virt_d = virt;
    assign frm_d  = frm;
    assign armed  = 1'b1;
  end

  // R1: M and the unused level raise nothing mode-dependent
  assert_m_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && lvl_d[1]) |-> ((ill_o & ~MODE_FREE) == '0 && vrt_o == '0 && !flush_o));

  // R2: virtual faults need virtualization on
  assert_virt_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !virt_d) |-> (vrt_o == '0));

  // R3: any guest mode faults hypervisor fences and load/store as virtual
  assert_guest_hyp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && virt_d && !lvl_d[1]) |-> (vrt_o[VF_HFENCE] && vrt_o[VF_HLDST]));

  // R4: wait-for-interrupt always illegal in HU
  assert_hu_wfi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && lvl_d == LVL_U && !virt_d) |-> ill_o[IL_WFI]);

  // R5: legal rounding modes never flag reserved
  assert_frm_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && frm_d <= FRM_W'(FRM_MAX)) |-> !ill_o[IL_FRMRSV]);

  // R10: a class never faults both ways at once for the translation fence in guest modes
  assert_no_dual_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !(ill_o[IL_ATFENCE] && vrt_o[VF_ATFENCE]));
endmodule

bind priv_legality_check plc_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .priv_lvl (priv_lvl),
  .virt     (virt),
  .frm      (frm),
  .ill_o    (ill_o),
  .vrt_o    (vrt_o),
  .flush_o  (flush_o)
);

// File: tb/test_priv_legality_check.sv
`timescale 1ns/1ps
module test_priv_legality_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [26:0] stim = '0;

  logic [11:0] ill_q, ill_c;
  logic [7:0]  vrt_q, vrt_c;
  logic        fl_q, fl_c;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  priv_legality_check #(.REG_OUT(1'b1)) i_priv_legality_check (
    .clk(clk), .rst_n(rst_n),
    .priv_lvl(stim[1:0]), .virt(stim[2]), .tvm(stim[3]), .tw(stim[4]),
    .vtvm(stim[5]), .vtw(stim[6]), .hu_en(stim[7]),
    .fs_state(stim[9:8]), .vs_state(stim[11:10]), .frm(stim[14:12]),
    .cbz_en(stim[17:15]), .cbcf_en(stim[20:18]),
    .cbi_m(stim[22:21]), .cbi_h(stim[24:23]), .cbi_s(stim[26:25]),
    .ill_o(ill_q), .vrt_o(vrt_q), .flush_o(fl_q));

  priv_legality_check #(.REG_OUT(1'b0)) i_priv_legality_check_c (
    .clk(clk), .rst_n(rst_n),
    .priv_lvl(stim[1:0]), .virt(stim[2]), .tvm(stim[3]), .tw(stim[4]),
    .vtvm(stim[5]), .vtw(stim[6]), .hu_en(stim[7]),
    .fs_state(stim[9:8]), .vs_state(stim[11:10]), .frm(stim[14:12]),
    .cbz_en(stim[17:15]), .cbcf_en(stim[20:18]),
    .cbi_m(stim[22:21]), .cbi_h(stim[24:23]), .cbi_s(stim[26:25]),
    .ill_o(ill_c), .vrt_o(vrt_c), .flush_o(fl_c));

  // reference model: returns {flush, vrt[7:0], ill[11:0]}
  function automatic logic [20:0] model(input logic [26:0] s);
    logic m, hs, hu, vs, vu, lo;
    logic [2:0] z, c;
    logic mo, ho, so, mf, hf, sf;
    logic [11:0] il;
    logic [7:0] vr;
    m  = (s[1:0] == 2'd3);
    hs = (s[1:0] == 2'd1) && !s[2];
    vs = (s[1:0] == 2'd1) &&  s[2];
    hu = (s[1:0] == 2'd0) && !s[2];
    vu = (s[1:0] == 2'd0) &&  s[2];
    lo = hs || hu || vs || vu;
    z = s[17:15]; c = s[20:18];
    mo = (s[22:21] == 2'b00) || (s[22:21] == 2'b10);
    ho = (s[24:23] == 2'b00) || (s[24:23] == 2'b10);
    so = (s[26:25] == 2'b00) || (s[26:25] == 2'b10);
    mf = (s[22:21] == 2'b01); hf = (s[24:23] == 2'b01); sf = (s[26:25] == 2'b01);
    il[0]  = (hs && s[3]) || hu;
    il[1]  = hu;
    il[2]  = (hs && s[3]) || hu;
    il[3]  = hu;
    il[4]  = hu && !s[7];
    il[5]  = (s[9:8] == 2'b00);
    il[6]  = (s[11:10] == 2'b00);
    il[7]  = hu || (lo && s[4]);
    il[8]  = (s[14:12] > 3'd4);
    il[9]  = (lo && !z[0]) || (hu && !z[2]);
    il[10] = (lo && !c[0]) || (hu && !c[2]);
    il[11] = (lo && mo) || (hu && so);
    vr[0] = (vs && s[5]) || vu;
    vr[1] = vu;
    vr[2] = vs || vu;
    vr[3] = vs || vu;
    vr[4] = (vu && !s[4]) || (vs && !s[4] && s[6]);
    vr[5] = z[0] && ((vs && !z[1]) || (vu && (!z[1] || !z[2])));
    vr[6] = c[0] && ((vs && !c[1]) || (vu && (!c[1] || !c[2])));
    vr[7] = !mo && (((vs || vu) && ho) || (vu && so));
    model = {(hs && mf) || (hu && (mf || sf)) || (vs && (mf || hf)) || (vu && (mf || hf || sf)), vr, il};
    if (m) model = model;
  endfunction

  function automatic string req_of(input int b);
    case (b)
      0, 1, 2, 12, 13: req_of = "R2";
      3, 4, 14, 15:    req_of = "R3";
      7, 16:           req_of = "R4";
      5, 6, 8:         req_of = "R5";
      9, 17:           req_of = "R6";
      10, 18:          req_of = "R7";
      11, 19:          req_of = "R8";
      default:         req_of = "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      for (int b = 0; b < 21; b++) begin
        if (act[b] !== exp[b]) begin
          $display("FAIL %s %s bit %0d stim=%h act=%h exp=%h", tag, req_of(b), b, stim, act, exp);
          break;
        end
      end
    end
  endtask

  // applies one vector; comb variant checked in-cycle, registered after the edge (R10)
  task automatic apply(input logic [26:0] v, input string tag);
    @(negedge clk);
    stim = v;
    #1;
    check({tag, " comb R10"}, {fl_c, vrt_c, ill_c}, model(v));
    @(posedge clk);
    #1;
    check({tag, " reg R10"}, {fl_q, vrt_q, ill_q}, model(v));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10 act=%0d expected below 100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [26:0] v;
    void'($urandom(32'h1d2c3b4a));

    // R10: reset clears registered flags while inputs would raise many
    stim = '0;
    repeat (3) @(posedge clk);
    #1;
    check("reset R10", {fl_q, vrt_q, ill_q}, 21'd0);
    check("reset comb R10", {fl_c, vrt_c, ill_c}, model(stim));
    @(negedge clk);
    rst_n = 1'b1;

    // R1: M mode and unused level 2, every virt value, all enables off
    for (int l = 2; l < 4; l++) begin
      for (int vb = 0; vb < 2; vb++) begin
        v = '0;
        v[1:0] = 2'(l);
        v[2] = 1'(vb);
        v[4] = 1'b1;
        apply(v, "R1 quiet mode");
      end
    end

    // R2/R3/R4: each mode with all trap bits set then cleared
    for (int md = 0; md < 8; md++) begin
      v = '1;
      v[2:0] = 3'(md);
      apply(v, "R2 R3 R4 traps set");
      v[7:3] = '0;
      apply(v, "R2 R3 R4 traps clear");
    end

    // R5: rounding mode boundary 4 vs 5, status fields off vs on
    for (int f = 0; f < 8; f++) begin
      v = '0;
      v[1:0] = 2'd3;
      v[14:12] = 3'(f);
      v[9:8] = 2'(f & 3);
      v[11:10] = 2'((f >> 1) & 3);
      apply(v, "R5 fp vec frm");
    end

    // R6/R7: one tier cleared at a time in every mode
    for (int md = 0; md < 8; md++) begin
      for (int t = 0; t < 3; t++) begin
        v = '0;
        v[2:0] = 3'(md);
        v[17:15] = ~(3'd1 << t);
        v[20:18] = ~(3'd1 << t);
        apply(v, "R6 R7 tier");
      end
    end

    // R8/R9: every invalidate code on one tier with others Invalidate, incl. reserved 10
    for (int md = 0; md < 8; md++) begin
      for (int t = 0; t < 3; t++) begin
        for (int code = 0; code < 4; code++) begin
          v = '0;
          v[2:0] = 3'(md);
          v[26:21] = 6'b111111;
          v[21 + 2*t +: 2] = 2'(code);
          apply(v, "R8 R9 inval code");
        end
      end
    end

    // random mix over all inputs
    for (int i = 0; i < 3000; i++) begin
      v = 27'($urandom());
      apply(v, "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule